// File: doc/BRIEF.md
# SCL/SDA Phase Timing Generator

This block sits inside a serial bus controller that shares one bus between legacy I2C targets and I3C targets. It produces the SCL clock and decides when SDA may change, by counting cycles of the controller clock against programmable cycle counts. A mode input chooses between five bus timings: Fast Mode, Fast Mode Plus, I3C open-drain, I3C push-pull single data rate, and I3C double data rate. Each mode has its own pair of low and high counts. A shared hold count places each SDA change after SCL falls, and a shared free count times the bus-free interval and the I3C start and stop margins.

A controller above the block issues one bus operation at a time: START, repeated START, one data bit with its value, or STOP. The block turns each operation into a short series of phases. Each phase holds fixed SCL and SDA levels for a counted number of cycles. A one-cycle done strobe marks the last cycle of every operation. A request presented in that cycle is taken at once, so a stream of bits leaves no idle gap on the bus. Byte framing, acknowledge handling, command processing, glitch filtering and pad cells are all handled elsewhere.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is held and after it is released with no request, scl_o=1, sda_o=1, sda_oe=0 and done=0.
- R2: A data bit (req_op=2) drives SCL low for L cycles and then high for H cycles, with SDA held at req_bit through the high phase. L and H come from the pair that mode selects: 0 Fast Mode, 1 Fast Mode Plus, 2 open-drain, 3 push-pull. A count of zero is treated as one.
- R3: In every operation except START, SCL falls first and SDA keeps its previous level for T cycles, where T is hold_cyc. SDA then takes its new level for the remaining L-T cycles of the low phase.
- R4: When hold_cyc is at or above the effective L, T is clamped to L-1, so at least one setup cycle always remains.
- R5: In double data rate mode (mode=4), both the low phase and the high phase last pp_high_cyc cycles, and pp_low_cyc is not used.
- R6: START (req_op=0) keeps SCL and SDA high for F cycles, where F is free_cyc. It then pulls SDA low while SCL stays high for E cycles. E is H in modes 0 and 1 and F in modes 2 to 4.
- R7: Repeated START (req_op=1) runs the low phase with SDA rising to 1. SCL then stays high for E cycles with SDA high, and for another E cycles with SDA low.
- R8: STOP (req_op=3) runs the low phase with SDA at 0. SCL then stays high for E cycles with SDA low, and finally releases SDA high for one cycle.
- R9: In modes 0 to 2, sda_oe is the inverse of sda_o, so the block drives only lows. In modes 3 and 4, sda_oe is 1.
- R10: done is high for exactly the final cycle of each operation. A request present in that cycle starts at the next clock edge, and its first phase levels appear with no gap.
- R11: All counts and the mode are captured when an operation is accepted. A change made while the operation runs affects only later operations.
- R12: A request, or a change of req_op or req_bit, while an operation is running and done is low, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Bus timing select, 0 to 4 |
| req_valid | input | 1 | Operation request |
| req_op | input | 2 | 0 START, 1 repeated START, 2 data bit, 3 STOP |
| req_bit | input | 1 | Data bit value |
| fm_low_cyc | input | CW | Fast Mode low count |
| fm_high_cyc | input | CW | Fast Mode high count |
| fmp_low_cyc | input | CW | Fast Mode Plus low count |
| fmp_high_cyc | input | CW | Fast Mode Plus high count |
| od_low_cyc | input | CW | Open-drain low count |
| od_high_cyc | input | CW | Open-drain high count |
| pp_low_cyc | input | CW | Push-pull low count |
| pp_high_cyc | input | CW | Push-pull high count, and double data rate low and high count |
| hold_cyc | input | CW | SDA hold after SCL falls |
| free_cyc | input | CW | Bus-free and I3C start/stop margin count |
| scl_o | output | 1 | SCL level |
| sda_o | output | 1 | SDA level to present |
| sda_oe | output | 1 | SDA output enable |
| done | output | 1 | Last cycle of the current operation |

## Verification
A request accepted at a clock edge shows its first phase levels in the cycle right after that edge. Each phase then holds its levels for exactly its count of cycles. done is high during the last of those cycles. In that same cycle the next request is taken, and the next operation's levels start one cycle later. The bench turns every operation into one expected item per cycle from the captured counts and queues the items. It adds a single idle item when the request is raised from an idle bus, because acceptance costs that one cycle. A monitor pops one item at each falling edge and compares SCL, SDA, output enable and done. Between operations, the monitor checks that the levels stay put and that done stays low.

// File: rtl/tg_pkg.sv
package tg_pkg;

    typedef enum logic [2:0] {
        MODE_FM  = 3'd0,
        MODE_FMP = 3'd1,
        MODE_OD  = 3'd2,
        MODE_PP  = 3'd3,
        MODE_DDR = 3'd4
    } tg_mode_e;

    typedef enum logic [1:0] {
        OP_START  = 2'd0,
        OP_RSTART = 2'd1,
        OP_BIT    = 2'd2,
        OP_STOP   = 2'd3
    } tg_op_e;

    // PH_IDLE must stay zero: the reset value of the sequencer relies on it
    typedef enum logic [3:0] {
        PH_IDLE   = 4'd0,
        PH_FREE   = 4'd1,   // both lines high, bus-free interval
        PH_SHOLD  = 4'd2,   // SDA low under high SCL (start hold)
        PH_LHOLD  = 4'd3,   // SCL low, SDA still at its old level
        PH_LSET   = 4'd4,   // SCL low, SDA at its new level
        PH_HIGH   = 4'd5,   // SCL high for a data bit
        PH_SSETUP = 4'd6,   // SDA high under high SCL before repeated start
        PH_PSETUP = 4'd7,   // SDA low under high SCL before stop
        PH_REL    = 4'd8    // SDA released high, end of stop
    } tg_phase_e;

endpackage

// File: rtl/tg_count_select.sv
module tg_count_select
    import tg_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic [2:0]    mode,
    input  logic [CW-1:0] fm_low_cyc,
    input  logic [CW-1:0] fm_high_cyc,
    input  logic [CW-1:0] fmp_low_cyc,
    input  logic [CW-1:0] fmp_high_cyc,
    input  logic [CW-1:0] od_low_cyc,
    input  logic [CW-1:0] od_high_cyc,
    input  logic [CW-1:0] pp_low_cyc,
    input  logic [CW-1:0] pp_high_cyc,
    input  logic [CW-1:0] hold_cyc,
    input  logic [CW-1:0] free_cyc,
    output logic [CW-1:0] low_len,
    output logic [CW-1:0] high_len,
    output logic [CW-1:0] hold_len,
    output logic [CW-1:0] free_len,
    output logic [CW-1:0] edge_len,
    output logic          is_od
);

    localparam logic [CW-1:0] ONE = CW'(1);

    function automatic logic [CW-1:0] floor_one(input logic [CW-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    tg_mode_e      m;
    logic [CW-1:0] raw_lo;
    logic [CW-1:0] raw_hi;
    logic          legacy;

    always_comb begin
        m = tg_mode_e'(mode);
        case (m)
            MODE_FMP: begin raw_lo = fmp_low_cyc; raw_hi = fmp_high_cyc; end
            MODE_OD:  begin raw_lo = od_low_cyc;  raw_hi = od_high_cyc;  end
            MODE_PP:  begin raw_lo = pp_low_cyc;  raw_hi = pp_high_cyc;  end
            // double data rate: the low phase borrows the high count
            MODE_DDR: begin raw_lo = pp_high_cyc; raw_hi = pp_high_cyc; end
            default:  begin raw_lo = fm_low_cyc;  raw_hi = fm_high_cyc;  end
        endcase

        legacy   = !(m inside {MODE_OD, MODE_PP, MODE_DDR});
        is_od    = !(m inside {MODE_PP, MODE_DDR});

        low_len  = floor_one(raw_lo);
        high_len = floor_one(raw_hi);
        free_len = floor_one(free_cyc);
        hold_len = (hold_cyc >= low_len) ? (low_len - ONE) : hold_cyc;
        edge_len = legacy ? high_len : free_len;
    end

endmodule

// File: rtl/tg_phase_seq.sv
module tg_phase_seq
    import tg_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic          req_bit,
    input  logic [CW-1:0] low_len,
    input  logic [CW-1:0] high_len,
    input  logic [CW-1:0] hold_len,
    input  logic [CW-1:0] free_len,
    input  logic [CW-1:0] edge_len,
    input  logic          is_od,
    output logic          scl_lvl,
    output logic          sda_lvl,
    output logic          fin,
    output logic          lat_od,
    output logic          lat_hold_nz
);

    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] low;
        logic [CW-1:0] high;
        logic [CW-1:0] hold;
        logic [CW-1:0] free;
        logic [CW-1:0] edge_c;
        logic          od;
    } tim_t;

    typedef struct packed {
        tg_phase_e     ph;
        tg_op_e        op;
        logic          dbit;
        tim_t          tim;
        logic [CW-1:0] cnt;
        logic          scl;
        logic          sda;
    } st_t;

    function automatic tg_phase_e first_phase(input tg_op_e op, input tim_t t);
        if (op == OP_START)  return PH_FREE;
        else if (t.hold != '0) return PH_LHOLD;
        else                 return PH_LSET;
    endfunction

    function automatic tg_phase_e next_phase(input tg_op_e op, input tg_phase_e ph);
        case (ph)
            PH_FREE:   return PH_SHOLD;
            PH_LHOLD:  return PH_LSET;
            PH_LSET: begin
                case (op)
                    OP_BIT:    return PH_HIGH;
                    OP_RSTART: return PH_SSETUP;
                    default:   return PH_PSETUP;
                endcase
            end
            PH_SSETUP: return PH_SHOLD;
            PH_PSETUP: return PH_REL;
            default:   return PH_IDLE;
        endcase
    endfunction

    function automatic logic [CW-1:0] phase_len(input tg_phase_e ph, input tim_t t);
        case (ph)
            PH_FREE:                        return t.free;
            PH_SHOLD, PH_SSETUP, PH_PSETUP: return t.edge_c;
            PH_LHOLD:                       return t.hold;
            PH_LSET:                        return t.low - t.hold;
            PH_HIGH:                        return t.high;
            default:                        return ONE;
        endcase
    endfunction

    function automatic logic scl_of(input tg_phase_e ph);
        return !(ph inside {PH_LHOLD, PH_LSET});
    endfunction

    function automatic logic sda_of(input tg_phase_e ph, input tg_op_e op,
                                    input logic b, input logic prev);
        case (ph)
            PH_LSET:                    return (op == OP_BIT) ? b : (op == OP_RSTART);
            PH_HIGH:                    return b;
            PH_FREE, PH_SSETUP, PH_REL: return 1'b1;
            PH_SHOLD, PH_PSETUP:        return 1'b0;
            default:                    return prev;
        endcase
    endfunction

    st_t       q, d;
    tim_t      tim_in;
    tg_op_e    op_in;
    tg_phase_e nxt;
    logic      busy;

    always_comb begin
        tim_in = '{low: low_len, high: high_len, hold: hold_len,
                   free: free_len, edge_c: edge_len, od: is_od};
        op_in  = tg_op_e'(req_op);
        nxt    = next_phase(q.op, q.ph);
        busy   = (q.ph != PH_IDLE);
        fin    = busy && (q.cnt == ONE) && (nxt == PH_IDLE);
        d      = q;

        if (!busy || fin) begin
            if (req_valid) begin
                d.op   = op_in;
                d.dbit = req_bit;
                d.tim  = tim_in;
                d.ph   = first_phase(op_in, tim_in);
                d.cnt  = phase_len(d.ph, tim_in);
                d.scl  = scl_of(d.ph);
                d.sda  = sda_of(d.ph, op_in, req_bit, q.sda);
            end else begin
                d.ph   = PH_IDLE;
            end
        end else if (q.cnt == ONE) begin
            d.ph  = nxt;
            d.cnt = phase_len(nxt, q.tim);
            d.scl = scl_of(nxt);
            d.sda = sda_of(nxt, q.op, q.dbit, q.sda);
        end else begin
            d.cnt = q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.tim.od <= 1'b1;
            q.scl    <= 1'b1;
            q.sda    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign scl_lvl     = q.scl;
    assign sda_lvl     = q.sda;
    assign lat_od      = q.tim.od;
    assign lat_hold_nz = (q.tim.hold != '0);

endmodule

// File: rtl/tg_sda_pad.sv
module tg_sda_pad (
    input  logic sda_lvl,
    input  logic od,
    output logic sda_o,
    output logic sda_oe
);

    always_comb begin
        sda_o  = sda_lvl;
        sda_oe = od ? !sda_lvl : 1'b1;
    end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic          req_bit,
    input  logic [CW-1:0] fm_low_cyc,
    input  logic [CW-1:0] fm_high_cyc,
    input  logic [CW-1:0] fmp_low_cyc,
    input  logic [CW-1:0] fmp_high_cyc,
    input  logic [CW-1:0] od_low_cyc,
    input  logic [CW-1:0] od_high_cyc,
    input  logic [CW-1:0] pp_low_cyc,
    input  logic [CW-1:0] pp_high_cyc,
    input  logic [CW-1:0] hold_cyc,
    input  logic [CW-1:0] free_cyc,
    output logic          scl_o,
    output logic          sda_o,
    output logic          sda_oe,
    output logic          done
);

    logic [CW-1:0] low_len, high_len, hold_len, free_len, edge_len;
    logic          is_od;
    logic          sda_lvl;
    logic          lat_od;
    logic          lat_hold_nz;

    tg_count_select #(.CW(CW)) u_sel (
        .mode         (mode),
        .fm_low_cyc   (fm_low_cyc),
        .fm_high_cyc  (fm_high_cyc),
        .fmp_low_cyc  (fmp_low_cyc),
        .fmp_high_cyc (fmp_high_cyc),
        .od_low_cyc   (od_low_cyc),
        .od_high_cyc  (od_high_cyc),
        .pp_low_cyc   (pp_low_cyc),
        .pp_high_cyc  (pp_high_cyc),
        .hold_cyc     (hold_cyc),
        .free_cyc     (free_cyc),
        .low_len      (low_len),
        .high_len     (high_len),
        .hold_len     (hold_len),
        .free_len     (free_len),
        .edge_len     (edge_len),
        .is_od        (is_od)
    );

    tg_phase_seq #(.CW(CW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_bit     (req_bit),
        .low_len     (low_len),
        .high_len    (high_len),
        .hold_len    (hold_len),
        .free_len    (free_len),
        .edge_len    (edge_len),
        .is_od       (is_od),
        .scl_lvl     (scl_o),
        .sda_lvl     (sda_lvl),
        .fin         (done),
        .lat_od      (lat_od),
        .lat_hold_nz (lat_hold_nz)
    );

    tg_sda_pad u_pad (
        .sda_lvl (sda_lvl),
        .od      (lat_od),
        .sda_o   (sda_o),
        .sda_oe  (sda_oe)
    );

endmodule

// File: rtl/tg_timing_chk.sv
module tg_timing_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_o,
    input logic sda_o,
    input logic sda_oe,
    input logic done,
    input logic lat_od,
    input logic lat_hold_nz
);

    // R2: SDA never changes on the edge where SCL rises
    a_r2_scl_rise_sda_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_o) |-> $stable(sda_o));

    // R3: with a nonzero hold, SDA keeps its level on the edge where SCL falls
    a_r3_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_hold_nz && $fell(scl_o)) |-> $stable(sda_o));

    // R6: SDA falls under a high SCL only if SCL was already high
    a_r6_start_edge_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_o) && scl_o) |-> $past(scl_o));

    // R9: open-drain modes only drive lows
    a_r9_od_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        lat_od |-> (sda_oe == !sda_o));

    // R9: push-pull modes drive both levels
    a_r9_pp_drives_both: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_od |-> sda_oe);

    // R10: done lasts one cycle
    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind scl_timing_gen tg_timing_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_o       (scl_o),
    .sda_o       (sda_o),
    .sda_oe      (sda_oe),
    .done        (done),
    .lat_od      (lat_od),
    .lat_hold_nz (lat_hold_nz)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;

    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic          req_bit = 1'b0;
    logic [2:0]    mode = 3'd0;
    logic [CW-1:0] fm_lo, fm_hi, fmp_lo, fmp_hi, od_lo, od_hi, pp_lo, pp_hi, hold_c, free_c;
    logic          scl_o, sda_o, sda_oe, done;

    scl_timing_gen #(.CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .req_valid(req_valid),
        .req_op(req_op), .req_bit(req_bit),
        .fm_low_cyc(fm_lo), .fm_high_cyc(fm_hi), .fmp_low_cyc(fmp_lo), .fmp_high_cyc(fmp_hi),
        .od_low_cyc(od_lo), .od_high_cyc(od_hi), .pp_low_cyc(pp_lo), .pp_high_cyc(pp_hi),
        .hold_cyc(hold_c), .free_cyc(free_c),
        .scl_o(scl_o), .sda_o(sda_o), .sda_oe(sda_oe), .done(done)
    );

    typedef struct {
        logic  scl;
        logic  sda;
        logic  oe;
        logic  dn;
        string tag;
    } item_t;

    item_t expq[$];
    int    checks = 0;
    int    fails = 0;
    int    n_items = 0;
    logic  idle_scl = 1'b1, idle_sda = 1'b1, idle_oe = 1'b0;
    logic  track_sda = 1'b1;
    bit    mon_on = 1'b0;

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // monitor: one expected item per cycle, sampled at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (expq.size() > 0) begin
                    item_t it;
                    it = expq.pop_front();
                    chk(it.tag, "scl",  scl_o,  it.scl);
                    chk(it.tag, "sda",  sda_o,  it.sda);
                    chk(it.tag, "oe",   sda_oe, it.oe);
                    chk(it.tag, "done", done,   it.dn);
                    idle_scl = it.scl;
                    idle_sda = it.sda;
                    idle_oe  = it.oe;
                end else begin
                    chk("R10-idle", "done", done, 1'b0);
                    chk("R12-idle", "scl", scl_o, idle_scl);
                    chk("R12-idle", "sda", sda_o, idle_sda);
                end
            end
        end
    end

    task automatic push_n(input logic s, input logic d, input int n, input bit od, input string tag);
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.scl = s;
            it.sda = d;
            it.oe  = od ? !d : 1'b1;
            it.dn  = 1'b0;
            it.tag = tag;
            expq.push_back(it);
            n_items++;
        end
        if (n > 0) track_sda = d;
    endtask

    // driver: builds the expected items for one operation from the requirements
    task automatic issue(input logic [1:0] op, input logic b, input string tag, input bit poke);
        int lo, hi, t, f, e;
        bit od, leg;
        logic tgt;
        case (mode)
            3'd1: begin lo = int'(fmp_lo); hi = int'(fmp_hi); end
            3'd2: begin lo = int'(od_lo);  hi = int'(od_hi);  end
            3'd3: begin lo = int'(pp_lo);  hi = int'(pp_hi);  end
            3'd4: begin lo = int'(pp_hi);  hi = int'(pp_hi);  end
            default: begin lo = int'(fm_lo); hi = int'(fm_hi); end
        endcase
        if (lo == 0) lo = 1;
        if (hi == 0) hi = 1;
        f   = (free_c == 0) ? 1 : int'(free_c);
        t   = (int'(hold_c) >= lo) ? lo - 1 : int'(hold_c);
        leg = (mode < 3'd2);
        od  = (mode < 3'd3);
        e   = leg ? hi : f;
        if (expq.size() == 0) begin
            item_t idl;
            idl.scl = idle_scl; idl.sda = idle_sda; idl.oe = idle_oe; idl.dn = 1'b0; idl.tag = tag;
            expq.push_back(idl);
        end
        n_items = 0;
        if (op == 2'd0) begin
            push_n(1'b1, 1'b1, f, od, tag);
            push_n(1'b1, 1'b0, e, od, tag);
        end else begin
            push_n(1'b0, track_sda, t, od, tag);
            tgt = (op == 2'd2) ? b : (op == 2'd1);
            push_n(1'b0, tgt, lo - t, od, tag);
            case (op)
                2'd2: push_n(1'b1, b, hi, od, tag);
                2'd1: begin push_n(1'b1, 1'b1, e, od, tag); push_n(1'b1, 1'b0, e, od, tag); end
                default: begin push_n(1'b1, 1'b0, e, od, tag); push_n(1'b1, 1'b1, 1, od, tag); end
            endcase
        end
        expq[expq.size()-1].dn = 1'b1;
        req_valid = 1'b1;
        req_op    = op;
        req_bit   = b;
        @(posedge clk);
        #1;
        // R12: scramble the request while the operation runs
        req_op  = op ^ 2'b01;
        req_bit = !b;
        // R11: change counts mid-operation; only later operations see them
        if (poke) begin
            fm_lo  = fm_lo + 8'd3;
            fm_hi  = fm_hi + 8'd1;
            hold_c = hold_c + 8'd1;
        end
        repeat (n_items - 1) @(posedge clk);
        #1;
    endtask

    task automatic quiet(input int n);
        req_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired with %0d items pending", expq.size());
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        fm_lo = 8'd6; fm_hi = 8'd4; fmp_lo = 8'd3; fmp_hi = 8'd2;
        od_lo = 8'd5; od_hi = 8'd3; pp_lo = 8'd2; pp_hi = 8'd3;
        hold_c = 8'd2; free_c = 8'd4;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset scl", scl_o, 1'b1);
        chk("R1", "reset sda", sda_o, 1'b1);
        chk("R1", "reset oe", sda_oe, 1'b0);
        chk("R1", "reset done", done, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "idle scl", scl_o, 1'b1);
        chk("R1", "idle oe", sda_oe, 1'b0);
        mon_on = 1'b1;

        // Fast Mode, back-to-back, with a mid-bit count change
        mode = 3'd0;
        issue(2'd0, 1'b0, "R6",  1'b0);
        issue(2'd2, 1'b1, "R2",  1'b0);
        issue(2'd2, 1'b0, "R3",  1'b0);
        issue(2'd2, 1'b1, "R10", 1'b1);
        issue(2'd2, 1'b0, "R11", 1'b0);
        issue(2'd1, 1'b0, "R7",  1'b0);
        issue(2'd2, 1'b0, "R2",  1'b0);
        issue(2'd3, 1'b0, "R8",  1'b0);
        quiet(3);

        // Fast Mode Plus
        mode = 3'd1;
        issue(2'd0, 1'b0, "R6", 1'b0);
        issue(2'd2, 1'b1, "R2", 1'b0);
        issue(2'd2, 1'b0, "R2", 1'b0);
        issue(2'd3, 1'b0, "R8", 1'b0);
        quiet(2);

        // open-drain I3C
        mode = 3'd2;
        issue(2'd0, 1'b0, "R6", 1'b0);
        issue(2'd2, 1'b0, "R9", 1'b0);
        issue(2'd2, 1'b1, "R9", 1'b0);
        issue(2'd1, 1'b0, "R7", 1'b0);
        issue(2'd2, 1'b0, "R2", 1'b0);
        issue(2'd3, 1'b0, "R8", 1'b0);
        quiet(2);

        // push-pull
        mode = 3'd3;
        issue(2'd0, 1'b0, "R6", 1'b0);
        issue(2'd2, 1'b1, "R9", 1'b0);
        issue(2'd2, 1'b0, "R9", 1'b0);
        issue(2'd3, 1'b0, "R8", 1'b0);
        quiet(2);

        // double data rate: low phase follows the high count
        mode = 3'd4; pp_lo = 8'd1; pp_hi = 8'd5;
        issue(2'd0, 1'b0, "R6", 1'b0);
        issue(2'd2, 1'b1, "R5", 1'b0);
        issue(2'd2, 1'b0, "R5", 1'b0);
        issue(2'd3, 1'b0, "R8", 1'b0);
        quiet(2);

        // hold clamp, then zero counts
        mode = 3'd0; fm_lo = 8'd3; fm_hi = 8'd2; hold_c = 8'd7;
        issue(2'd0, 1'b0, "R6", 1'b0);
        issue(2'd2, 1'b1, "R4", 1'b0);
        issue(2'd2, 1'b0, "R4", 1'b0);
        issue(2'd3, 1'b0, "R8", 1'b0);
        quiet(2);
        fm_lo = 8'd0; fm_hi = 8'd0; hold_c = 8'd0; free_c = 8'd0;
        issue(2'd0, 1'b0, "R4", 1'b0);
        issue(2'd2, 1'b1, "R4", 1'b0);
        issue(2'd2, 1'b0, "R4", 1'b0);
        issue(2'd1, 1'b0, "R7", 1'b0);
        issue(2'd3, 1'b0, "R8", 1'b0);
        quiet(4);

        wait (expq.size() == 0);
        repeat (2) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule